// File: doc/BRIEF.md
# Serial Modulo-3 Residue Tracker

This block follows a binary number that arrives one bit per clock, most significant bit first, and keeps its remainder after division by three. Each accepted bit doubles the value seen so far and adds the new bit. The block only needs the old remainder and the new bit to get the new remainder, so three states cover a number of any length. No bit counter is used.

A qualifier marks the cycles that carry a bit. A synchronous clear starts a new number. Two residue outputs are provided:

- The registered one reports the state, Moore style.
- The combinational one reports the residue that already includes the bit on the input this cycle, Mealy style. It therefore runs one cycle ahead of the registered output.

Top module: `mod3_serial_residue`

## Requirements
- R1: While `rst_ni` is low, `moore_res_o` is 0 (2'b00). Residues are coded as plain 2-bit binary 0, 1 and 2.
- R2: From residue 0, an accepted bit 0 keeps residue 0 and an accepted bit 1 gives residue 1.
- R3: From residue 1, an accepted bit 0 gives residue 2 and an accepted bit 1 gives residue 0.
- R4: From residue 2, an accepted bit 0 gives residue 1 and an accepted bit 1 keeps residue 2.
- R5: After a clear and then the bits of a number N, MSB first, `moore_res_o` equals N mod 3. For example, bits 1,1,0,1,0,1,0 (N = 106) end at residue 1.
- R6: In a cycle with `bit_valid_i` low and `clear_i` low, the state does not change, whatever `bit_i` is. In that cycle `mealy_res_o` equals `moore_res_o`.
- R7: `clear_i` high at a clock edge sets `moore_res_o` to 0 after that edge. This holds even when `bit_valid_i` is high in the same cycle.
- R8: When `bit_valid_i` is high, `mealy_res_o` shows the residue that includes `bit_i`. After the edge, `moore_res_o` takes that same value, unless a clear is applied.
- R9: Neither output ever shows the unused code 2'b11. If the state ever holds 2'b11, the next accepted bit returns it to residue 0.
- R10: Numbers of any length are tracked correctly, including inputs hundreds of bits long with no clear in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear; starts a new number |
| bit_valid_i | input | 1 | High when `bit_i` carries a data bit |
| bit_i | input | 1 | Serial data bit, most significant first |
| moore_res_o | output | 2 | Registered residue of the bits accepted so far |
| mealy_res_o | output | 2 | Residue that includes the present bit |

## Verification
The bench covers every arc of the three-state graph, starting from each residue with each bit value. A swapped arc would show up as a wrong residue one cycle after the bit is accepted.

It holds the qualifier low while `bit_i` toggles. A block that ignored the qualifier would drift away from the model, and a wrong Mealy path would not match the registered output in idle cycles.

It applies a clear together with a valid bit. A block that gave the bit priority over the clear would leave a nonzero residue behind.

It also feeds a long stream of bits from a shift-register generator, with no clear in between. Any stuck or lagging Mealy output shows up here against the one-cycle-later Moore value.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int unsigned RES_W = 2;

  typedef enum logic [RES_W-1:0] {
    RES_ZERO = 2'd0,
    RES_ONE  = 2'd1,
    RES_TWO  = 2'd2,
    RES_BAD  = 2'd3
  } res_e;
endpackage

// File: rtl/mod3_step.sv
module mod3_step
  import mod3_pkg::*;
(
  input  res_e cur_i,
  input  logic bit_i,
  output res_e nxt_o
);
  // new = (2*old + bit) mod 3
  always_comb begin
    unique case (cur_i)
      RES_ZERO: nxt_o = bit_i ? RES_ONE  : RES_ZERO;
      RES_ONE:  nxt_o = bit_i ? RES_ZERO : RES_TWO;
      RES_TWO:  nxt_o = bit_i ? RES_TWO  : RES_ONE;
      default:  nxt_o = RES_ZERO;  // unused code recovers
    endcase
  end
endmodule

// File: rtl/mod3_state.sv
module mod3_state
  import mod3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic load_i,
  input  res_e nxt_i,
  output res_e state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= RES_ZERO;
    else if (clear_i) state_o <= RES_ZERO;  // clear wins over load
    else if (load_i)  state_o <= nxt_i;
  end
endmodule

// File: rtl/mod3_serial_residue.sv
module mod3_serial_residue
  import mod3_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] moore_res_o,
  output logic [RES_W-1:0] mealy_res_o
);
  res_e state_q;
  res_e step_res;

  mod3_step u_step (
    .cur_i (state_q),
    .bit_i (bit_i),
    .nxt_o (step_res)
  );

  mod3_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .load_i  (bit_valid_i),
    .nxt_i   (step_res),
    .state_o (state_q)
  );

  assign moore_res_o = state_q;
  assign mealy_res_o = bit_valid_i ? step_res : state_q;
endmodule

// File: rtl/mod3_serial_residue_chk.sv
module mod3_serial_residue_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clear_i,
  input logic       bit_valid_i,
  input logic       bit_i,
  input logic [1:0] moore_res_o,
  input logic [1:0] mealy_res_o
);
  // R2 R3 R4 R5
  step_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && !clear_i) |=>
      (int'(moore_res_o) == (2*int'($past(moore_res_o)) + int'($past(bit_i))) % 3));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && !clear_i) |=> $stable(moore_res_o));

  // R6
  idle_mealy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |-> (mealy_res_o == moore_res_o));

  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (moore_res_o == 2'd0));

  // R8
  mealy_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && !clear_i) |=> (moore_res_o == $past(mealy_res_o)));

  // R9
  no_bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (moore_res_o != 2'd3) && (mealy_res_o != 2'd3));
endmodule

bind mod3_serial_residue mod3_serial_residue_chk u_chk (.*);

// File: tb/mod3_serial_residue_bench.sv
module mod3_serial_residue_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [1:0] moore_res_o;
  logic [1:0] mealy_res_o;

  int n_tests = 0;
  int n_fail  = 0;
  int model   = 0;
  bit done    = 1'b0;

  typedef struct { int exp; string req; } item_t;
  item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  mod3_serial_residue u_mod3_serial_residue (.*);

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: one call = one cycle; drive at negedge, push expected Moore value
  task automatic cycle(input bit clr, input bit vld, input bit b, input string req);
    item_t it;
    @(negedge clk_i);
    clear_i = clr; bit_valid_i = vld; bit_i = b;
    #1;
    if (vld) check({req, " R8 mealy"}, int'(mealy_res_o), (2*model + int'(b)) % 3);
    else     check({req, " R6 mealy idle"}, int'(mealy_res_o), model);
    if (clr)      model = 0;
    else if (vld) model = (2*model + int'(b)) % 3;
    it.exp = model; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compare after each edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        check(it.req, int'(moore_res_o), it.exp);
        check("R9 code", int'(moore_res_o == 2'd3), 0);
      end
    end
  end

  initial begin
    #20000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    logic [6:0] v106;
    repeat (3) @(posedge clk_i);
    #2 check("R1 reset", int'(moore_res_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 arcs from 0
    cycle(0, 1, 0, "R2 0-0");
    cycle(0, 1, 1, "R2 0-1");
    // R3 arcs from 1
    cycle(0, 1, 0, "R3 1-0");
    // R4 arcs from 2
    cycle(0, 1, 1, "R4 2-1");
    cycle(0, 1, 0, "R4 2-0");
    cycle(0, 1, 1, "R3 1-1");

    // R5 value 106, MSB first
    cycle(1, 0, 0, "R7 clear");
    v106 = 7'd106;
    for (int i = 6; i >= 0; i--) cycle(0, 1, v106[i], "R5 106");
    cycle(0, 0, 0, "R5 hold");
    check("R5 final", model, 1);

    // R6 idle with toggling data
    for (int i = 0; i < 6; i++) cycle(0, 0, i[0], "R6 idle");

    // R7 clear together with a valid bit
    cycle(0, 1, 1, "R7 pre");
    cycle(1, 1, 1, "R7 clear+valid");
    cycle(0, 1, 1, "R7 after");

    // R10 long stream
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      cycle(0, (i % 7) != 3, lfsr[7], "R10 stream");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    cycle(0, 0, 0, "R10 end");
    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule